// File: doc/BRIEF.md
# Bit Test and Single-Bit Modify Unit

This unit performs the bit-oriented operations of an enhanced 8-bit processor on operands that have already been fetched. Each cycle where `in_valid` is high, it takes a memory operand byte, the accumulator, a bit index, an operation code, the incoming N/V/Z flags, the address of the next instruction and a relative offset. One cycle later it presents registered results. These are the new N/V/Z flags, a write-back byte with a one-cycle write enable, and a branch decision with its target address.

The seven operations fall into three groups. Three test operations take N and V from operand bits 7 and 6 and Z from accumulator AND operand. Two of these also clear or set operand bits under the accumulator mask. Two operations clear or set the single bit chosen by the index. Two operations branch when the indexed bit is clear or when it is set. The remaining code is idle. Address generation and memory transfers happen outside the unit.

Top module: `bitop_unit`

## Requirements
- R1: While reset is asserted (`rst_n` low), `out_valid`, `wr_en`, `br_taken`, `flags_out`, `wr_data` and `br_target` are all zero.
- R2: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. All other outputs are registered from the inputs of that same cycle.
- R3: Bit test (op 0) sets flags_out = {N, V, Z}, where N is operand bit 7, V is operand bit 6 and Z is 1 exactly when (acc & operand) is zero. It does not write.
- R4: Test-and-clear (op 1) sets N, V and Z as in R3, using the original operand. It writes back operand & ~acc with `wr_en` high.
- R5: Test-and-set (op 2) sets N, V and Z as in R3, using the original operand. It writes back operand | acc with `wr_en` high.
- R6: Bit clear (op 3) writes back the operand with bit `bit_idx` forced to 0. `flags_out` equals `flags_in`.
- R7: Bit set (op 4) writes back the operand with bit `bit_idx` forced to 1. `flags_out` equals `flags_in`.
- R8: Branch-if-clear (op 5) raises `br_taken` exactly when operand bit `bit_idx` is 0. It does not write, and `flags_out` equals `flags_in`.
- R9: Branch-if-set (op 6) raises `br_taken` exactly when operand bit `bit_idx` is 1. It does not write, and `flags_out` equals `flags_in`.
- R10: `br_target` equals `next_pc` plus the sign-extended 8-bit `rel_off`, taken modulo 2^16.
- R11: Idle (op 7) leaves `wr_en` and `br_taken` low and passes `flags_in` through to `flags_out`.
- R12: `wr_en` is high only in a result cycle for ops 1 to 4. `wr_en` and `br_taken` are low in any cycle without a result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input strobe |
| op_sel | input | 3 | Operation code 0..7 |
| operand | input | 8 | Fetched memory byte |
| acc | input | 8 | Accumulator value |
| bit_idx | input | 3 | Selected bit position |
| flags_in | input | 3 | Current {N,V,Z} |
| next_pc | input | 16 | Address of next instruction |
| rel_off | input | 8 | Signed branch offset |
| out_valid | output | 1 | Result strobe |
| flags_out | output | 3 | Updated {N,V,Z} |
| wr_data | output | 8 | Write-back byte |
| wr_en | output | 1 | Write-back enable |
| br_taken | output | 1 | Branch decision |
| br_target | output | 16 | Branch destination |

## Verification
Every operation code is tried with all 256 operand values and all eight bit indices. The accumulator pattern changes with each step, so both zero and non-zero AND results occur. Because the operand's top two bits vary independently of the AND result, a design that took N or V from the result would be caught. A design that took Z from the written-back value would also be caught. The eight index values separate a correct mask from a shifted or inverted one. The offset sweep covers positive and negative values, together with addresses that wrap past 0xFFFF and below 0x0000.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
  typedef enum logic [2:0] {
    OP_TEST = 3'd0,
    OP_TCLR = 3'd1,
    OP_TSET = 3'd2,
    OP_BCLR = 3'd3,
    OP_BSET = 3'd4,
    OP_JCLR = 3'd5,
    OP_JSET = 3'd6,
    OP_IDLE = 3'd7
  } bitop_e;

  localparam int FLAG_N = 2;
  localparam int FLAG_V = 1;
  localparam int FLAG_Z = 0;
endpackage

// File: rtl/bitop_flags.sv
module bitop_flags
  import bitop_pkg::*;
#(
  parameter int DW = 8
) (
  input  bitop_e          op,
  input  logic [DW-1:0]   opnd,
  input  logic [DW-1:0]   acc,
  input  logic [2:0]      flags_in,
  output logic [2:0]      flags_nxt,
  output logic            is_test_op
);
  function automatic logic [2:0] f_test_flags(input logic [DW-1:0] o, input logic [DW-1:0] a);
    logic [2:0] f;
    f[FLAG_N] = o[DW-1];
    f[FLAG_V] = o[DW-2];
    f[FLAG_Z] = ((o & a) == '0);
    return f;
  endfunction

  always_comb begin
    is_test_op = (op == OP_TEST) || (op == OP_TCLR) || (op == OP_TSET);
    flags_nxt  = is_test_op ? f_test_flags(opnd, acc) : flags_in;
  end
endmodule

// File: rtl/bitop_modify.sv
module bitop_modify
  import bitop_pkg::*;
#(
  parameter int DW = 8,
  parameter int IW = $clog2(DW)
) (
  input  bitop_e          op,
  input  logic [DW-1:0]   opnd,
  input  logic [DW-1:0]   acc,
  input  logic [IW-1:0]   idx,
  output logic [DW-1:0]   wdata_nxt,
  output logic            we_nxt
);
  logic [DW-1:0] onehot;

  genvar gi;
  generate
    for (gi = 0; gi < DW; gi++) begin : g_mask
      assign onehot[gi] = (idx == IW'(gi));
    end
  endgenerate

  always_comb begin
    we_nxt    = 1'b0;
    wdata_nxt = opnd;
    case (op)
      OP_TCLR: begin we_nxt = 1'b1; wdata_nxt = opnd & ~acc;    end
      OP_TSET: begin we_nxt = 1'b1; wdata_nxt = opnd | acc;     end
      OP_BCLR: begin we_nxt = 1'b1; wdata_nxt = opnd & ~onehot; end
      OP_BSET: begin we_nxt = 1'b1; wdata_nxt = opnd | onehot;  end
      default: begin we_nxt = 1'b0; wdata_nxt = opnd;           end
    endcase
  end
endmodule

// File: rtl/bitop_branch.sv
module bitop_branch
  import bitop_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 16,
  parameter int IW = $clog2(DW)
) (
  input  bitop_e          op,
  input  logic [DW-1:0]   opnd,
  input  logic [IW-1:0]   idx,
  input  logic [AW-1:0]   next_pc,
  input  logic [DW-1:0]   rel_off,
  output logic            taken_nxt,
  output logic [AW-1:0]   target_nxt,
  output logic            sel_bit
);
  localparam int EXT = AW - DW;

  function automatic logic [AW-1:0] f_rel_target(input logic [AW-1:0] pc, input logic [DW-1:0] off);
    return pc + {{EXT{off[DW-1]}}, off};
  endfunction

  always_comb begin
    sel_bit    = opnd[idx];
    target_nxt = f_rel_target(next_pc, rel_off);
    case (op)
      OP_JCLR: taken_nxt = ~sel_bit;
      OP_JSET: taken_nxt = sel_bit;
      default: taken_nxt = 1'b0;
    endcase
  end
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import bitop_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 16,
  parameter int IW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [2:0]    op_sel,
  input  logic [DW-1:0] operand,
  input  logic [DW-1:0] acc,
  input  logic [IW-1:0] bit_idx,
  input  logic [2:0]    flags_in,
  input  logic [AW-1:0] next_pc,
  input  logic [DW-1:0] rel_off,
  output logic          out_valid,
  output logic [2:0]    flags_out,
  output logic [DW-1:0] wr_data,
  output logic          wr_en,
  output logic          br_taken,
  output logic [AW-1:0] br_target
);
  bitop_e        op;
  logic [2:0]    flags_nxt;
  logic          is_test_op;
  logic [DW-1:0] wdata_nxt;
  logic          we_nxt;
  logic          taken_nxt;
  logic [AW-1:0] target_nxt;
  logic          sel_bit;

  assign op = bitop_e'(op_sel);

  bitop_flags #(.DW(DW)) u_flags (
    .op(op), .opnd(operand), .acc(acc), .flags_in(flags_in),
    .flags_nxt(flags_nxt), .is_test_op(is_test_op)
  );

  bitop_modify #(.DW(DW), .IW(IW)) u_modify (
    .op(op), .opnd(operand), .acc(acc), .idx(bit_idx),
    .wdata_nxt(wdata_nxt), .we_nxt(we_nxt)
  );

  bitop_branch #(.DW(DW), .AW(AW), .IW(IW)) u_branch (
    .op(op), .opnd(operand), .idx(bit_idx), .next_pc(next_pc), .rel_off(rel_off),
    .taken_nxt(taken_nxt), .target_nxt(target_nxt), .sel_bit(sel_bit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      flags_out <= '0;
      wr_data   <= '0;
      wr_en     <= 1'b0;
      br_taken  <= 1'b0;
      br_target <= '0;
    end else begin
      out_valid <= in_valid;
      wr_en     <= in_valid & we_nxt;
      br_taken  <= in_valid & taken_nxt;
      if (in_valid) begin
        flags_out <= flags_nxt;
        wr_data   <= wdata_nxt;
        br_target <= target_nxt;
      end
    end
  end

  // R2: result strobe follows the input strobe by one cycle
  p_strobe_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_strobe_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R12: write enable only for modify ops, only with a result
  p_we_ops_r12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (out_valid && ($past(op_sel) >= 3'd1) && ($past(op_sel) <= 3'd4)));

  // R8 / R9: a taken branch only comes from a bit-branch op
  p_taken_ops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |-> (out_valid && ($past(op_sel) == 3'd5 || $past(op_sel) == 3'd6)));

  // R6: non-test ops leave flags as supplied
  p_flags_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !is_test_op) |=> (flags_out == $past(flags_in)));

  // R3: test ops take N and V from the raw operand
  p_nv_raw_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_test_op) |=> (flags_out[FLAG_N:FLAG_V] == $past(operand[DW-1:DW-2])));

  // R9: branch-if-set follows the selected bit
  p_jset_bit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_JSET) |=> (br_taken == $past(sel_bit)));
endmodule

// File: tb/bitop_unit_tb.sv
module bitop_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  op_sel = '0;
  logic [7:0]  operand = '0;
  logic [7:0]  acc = '0;
  logic [2:0]  bit_idx = '0;
  logic [2:0]  flags_in = '0;
  logic [15:0] next_pc = '0;
  logic [7:0]  rel_off = '0;
  logic        out_valid;
  logic [2:0]  flags_out;
  logic [7:0]  wr_data;
  logic        wr_en;
  logic        br_taken;
  logic [15:0] br_target;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitop_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .operand(operand), .acc(acc), .bit_idx(bit_idx), .flags_in(flags_in),
    .next_pc(next_pc), .rel_off(rel_off), .out_valid(out_valid),
    .flags_out(flags_out), .wr_data(wr_data), .wr_en(wr_en),
    .br_taken(br_taken), .br_target(br_target)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic run_op(input int op, input int opd, input int a, input int idx,
                        input int fin, input int pc, input int off);
    int  bitv, e_wd, e_we, e_tk, e_tg, e_fl, sx;
    bitv = (opd / (1 << idx)) % 2;
    e_wd = opd; e_we = 0; e_tk = 0; e_fl = fin;
    if (op <= 2) e_fl = ((opd / 128) % 2) * 4 + ((opd / 64) % 2) * 2 + (((opd & a) == 0) ? 1 : 0);
    case (op)
      1: begin e_we = 1; e_wd = opd & (255 - a); end
      2: begin e_we = 1; e_wd = opd | a; end
      3: begin e_we = 1; e_wd = (bitv == 1) ? opd - (1 << idx) : opd; end
      4: begin e_we = 1; e_wd = (bitv == 0) ? opd + (1 << idx) : opd; end
      5: e_tk = (bitv == 0) ? 1 : 0;
      6: e_tk = bitv;
      default: ;
    endcase
    sx = (off >= 128) ? off - 256 : off;
    e_tg = (pc + sx + 65536) % 65536;

    @(negedge clk);
    in_valid = 1'b1; op_sel = 3'(op); operand = 8'(opd); acc = 8'(a);
    bit_idx = 3'(idx); flags_in = 3'(fin); next_pc = 16'(pc); rel_off = 8'(off);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R2 out_valid", 16'(out_valid), 16'd1);
    case (op)
      0: chk("R3 flags", 16'(flags_out), 16'(e_fl));
      1: chk("R4 flags", 16'(flags_out), 16'(e_fl));
      2: chk("R5 flags", 16'(flags_out), 16'(e_fl));
      3: chk("R6 flags", 16'(flags_out), 16'(e_fl));
      4: chk("R7 flags", 16'(flags_out), 16'(e_fl));
      5: chk("R8 flags", 16'(flags_out), 16'(e_fl));
      6: chk("R9 flags", 16'(flags_out), 16'(e_fl));
      default: chk("R11 flags", 16'(flags_out), 16'(e_fl));
    endcase
    chk("R12 wr_en", 16'(wr_en), 16'(e_we));
    if (e_we == 1) begin
      case (op)
        1: chk("R4 wr_data", 16'(wr_data), 16'(e_wd));
        2: chk("R5 wr_data", 16'(wr_data), 16'(e_wd));
        3: chk("R6 wr_data", 16'(wr_data), 16'(e_wd));
        default: chk("R7 wr_data", 16'(wr_data), 16'(e_wd));
      endcase
    end
    if (op == 5)      chk("R8 br_taken", 16'(br_taken), 16'(e_tk));
    else if (op == 6) chk("R9 br_taken", 16'(br_taken), 16'(e_tk));
    else              chk("R11 br_taken", 16'(br_taken), 16'(e_tk));
    chk("R10 br_target", br_target, 16'(e_tg));
    @(negedge clk);
    chk("R2 out_valid low", 16'(out_valid), 16'd0);
    chk("R12 wr_en low", 16'(wr_en), 16'd0);
    chk("R12 br_taken low", 16'(br_taken), 16'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 out_valid", 16'(out_valid), 16'd0);
    chk("R1 wr_en", 16'(wr_en), 16'd0);
    chk("R1 br_taken", 16'(br_taken), 16'd0);
    chk("R1 flags_out", 16'(flags_out), 16'd0);
    chk("R1 wr_data", 16'(wr_data), 16'd0);
    chk("R1 br_target", br_target, 16'd0);
    rst_n = 1'b1;

    // R3/R4/R5 corner cases: zero AND, full AND, raw bits vs result
    run_op(0, 8'hC0, 8'h00, 0, 0, 16'h1000, 8'h00);
    run_op(1, 8'hFF, 8'hFF, 0, 0, 16'h1000, 8'h00);
    run_op(2, 8'h00, 8'h5A, 0, 7, 16'h1000, 8'h00);
    run_op(1, 8'h41, 8'h01, 0, 0, 16'h1000, 8'h00);
    // R10 wrap corners
    run_op(6, 8'h80, 8'h00, 7, 0, 16'hFFFF, 8'h01);
    run_op(5, 8'h00, 8'h00, 3, 0, 16'h0000, 8'h80);
    run_op(5, 8'h00, 8'h00, 3, 0, 16'hFF90, 8'h7F);

    // sweep: all ops x all operands x all indices
    for (int op = 0; op < 8; op++)
      for (int opd = 0; opd < 256; opd++)
        for (int idx = 0; idx < 8; idx++)
          run_op(op, opd, (opd * 73 + idx * 29 + op * 11 + 5) % 256, idx,
                 (opd + idx + op) % 8, (opd * 257 + idx * 4099 + op * 31) % 65536,
                 (opd * 13 + idx * 37) % 256);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule